// File: doc/BRIEF.md
# Cascadable Serial Configuration ROM

This block is a bit-serial read-only store. It streams a fixed configuration image to a loading device one bit per clock. An internal address counter starts at zero after reset. It moves forward on each rising clock edge while the chip is selected, and the bit at the current address is presented on the serial data output so that the receiver can sample it on the next edge. The image is fixed by a parameter: bit `a` of `IMAGE` is the bit stored at address `a`.

One pin does two jobs. In one state it clears the counter and releases the data line; in the other it lets the data output drive. A parameter chooses which level means reset. When the last stored bit has been delivered, the part stops driving the shared data line and raises a cascade enable. That enable selects the next ROM in a chain, so several parts on a common clock and data line can deliver one long stream.

Top module: `serial_cfg_rom`

## Requirements
- R1: While the reset pin is at its reset level, `dataOutEn` and `cascadeEn` are 0 at once, and the counter is cleared to address 0 at the next rising clock edge.
- R2: With `RESET_HIGH`=1 a high `oeRst` is the reset level and a low `oeRst` enables output. With `RESET_HIGH`=0 the two levels are swapped.
- R3: On each rising edge with `chipEn`=1, the pin not at its reset level and the stream not finished, the address advances by exactly one.
- R4: After reset, while `dataOutEn`=1, `dataOut` carries `IMAGE[addr]`, so the driven stream is `IMAGE[0]`, `IMAGE[1]`, and so on in ascending order.
- R5: While `chipEn`=0 the address does not change, and `dataOutEn` is 0.
- R6: `dataOutEn` is 1 exactly when `chipEn`=1, the pin is not at its reset level and the stream is not finished. While `dataOutEn`=0, `dataOut` is 0.
- R7: The edge that consumes address `DEPTH`-1 finishes the stream. After that the address holds at `DEPTH`-1 and does not wrap, and the data output stays released until the next reset.
- R8: `cascadeEn` is 1 exactly when the stream is finished, `chipEn`=1 and the pin is not at its reset level. It is never 1 together with `dataOutEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock from the loading device |
| chipEn | input | 1 | Chip select, active high (driven by the previous ROM's `cascadeEn` in a chain) |
| oeRst | input | 1 | Combined output-enable / reset pin; polarity set by `RESET_HIGH` |
| dataOut | output | 1 | Serial data bit; valid only while `dataOutEn` is 1 |
| dataOutEn | output | 1 | Drive enable for the tri-state data line |
| cascadeEn | output | 1 | Selects the next ROM once this one has finished |

## Verification
A wrong address value shows on `dataOut` in the very next cycle in which the part drives. The image is chosen without short repeats, so a skipped, repeated or wrapped address produces a bit that differs from the expected stream within a few cycles. A wrong finished flag shows in the same cycle at both `dataOutEn` and `cascadeEn`, because both are derived from that flag and the two pins. Two instances with opposite polarity settings are driven with the same logical reset, so a reversed polarity decode shows at once as an enable mismatch.

// File: rtl/serrom_pkg.sv
package serrom_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // counter back to zero
    logic advance;  // counter plus one
  } ctlStrobe_t;
endpackage

// File: rtl/serrom_path.sv
module serrom_path
  import serrom_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter logic [DEPTH-1:0] IMAGE = '0
) (
  input  logic       clk,
  input  ctlStrobe_t strobe,
  output logic       atLast,
  output logic       bitOut
);
  localparam int ADDR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr;

  always_ff @(posedge clk) begin
    if (strobe.clear)        addr <= '0;
    else if (strobe.advance) addr <= addr + 1'b1;
  end

  assign atLast = (addr == LAST_ADDR);
  assign bitOut = IMAGE[addr];

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.advance |=> addr == $past(addr) + 1'b1);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.advance |=> $stable(addr));

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    atLast |-> !strobe.advance);
endmodule

// File: rtl/serrom_ctrl.sv
module serrom_ctrl
  import serrom_pkg::*;
(
  input  logic       clk,
  input  logic       rstAct,
  input  logic       chipEn,
  input  logic       atLast,
  output ctlStrobe_t strobe,
  output logic       dataOutEn,
  output logic       cascadeEn
);
  logic done;
  logic running;

  assign running        = chipEn && !rstAct && !done;
  assign strobe.clear   = rstAct;
  assign strobe.advance = running && !atLast;

  always_ff @(posedge clk) begin
    if (rstAct)                 done <= 1'b0;
    else if (running && atLast) done <= 1'b1;
  end

  assign dataOutEn = running;
  assign cascadeEn = done && chipEn && !rstAct;

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (rstAct)
    done |=> done);

  // R7
  done_at_end_chk: assert property (@(posedge clk) disable iff (rstAct)
    done |-> atLast);

  // R8
  drive_excl_chk: assert property (@(posedge clk) disable iff (rstAct)
    !(dataOutEn && cascadeEn));
endmodule

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom
  import serrom_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter bit RESET_HIGH = 1'b0,
  parameter logic [DEPTH-1:0] IMAGE = 64'hC3A5_0F1E_9B27_D448
) (
  input  logic clk,
  input  logic chipEn,
  input  logic oeRst,
  output logic dataOut,
  output logic dataOutEn,
  output logic cascadeEn
);
  logic       rstAct;
  logic       atLast;
  logic       bitOut;
  ctlStrobe_t strobe;

  generate
    if (RESET_HIGH) begin : g_rstHigh
      assign rstAct = oeRst;
    end else begin : g_rstLow
      assign rstAct = !oeRst;
    end
  endgenerate

  serrom_ctrl u_ctrl (
    .clk      (clk),
    .rstAct   (rstAct),
    .chipEn   (chipEn),
    .atLast   (atLast),
    .strobe   (strobe),
    .dataOutEn(dataOutEn),
    .cascadeEn(cascadeEn)
  );

  serrom_path #(.DEPTH(DEPTH), .IMAGE(IMAGE)) u_path (
    .clk   (clk),
    .strobe(strobe),
    .atLast(atLast),
    .bitOut(bitOut)
  );

  assign dataOut = dataOutEn & bitOut;

  // R6
  quiet_line_chk: assert property (@(posedge clk) !dataOutEn |-> !dataOut);

  // R1
  rst_release_chk: assert property (@(posedge clk)
    rstAct |-> !dataOutEn && !cascadeEn);
endmodule

// File: tb/sim_serial_cfg_rom.sv
module sim_serial_cfg_rom;
  localparam int DEPTH = 64;
  localparam logic [63:0] IMG = 64'hC3A5_0F1E_9B27_D448;

  logic clk = 1'b0;
  logic ce = 1'b0;
  logic rst = 1'b1;
  logic pinLo, pinHi;
  logic doLo, enLo, caLo, doHi, enHi, caHi;
  int checks = 0;
  int fails = 0;
  int mAddr = 0;
  bit mDone = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // R2: one pin level per polarity setting
  assign pinLo = !rst;
  assign pinHi = rst;

  serial_cfg_rom #(.DEPTH(DEPTH), .RESET_HIGH(1'b0), .IMAGE(IMG)) u0 (
    .clk(clk), .chipEn(ce), .oeRst(pinLo),
    .dataOut(doLo), .dataOutEn(enLo), .cascadeEn(caLo));

  serial_cfg_rom #(.DEPTH(DEPTH), .RESET_HIGH(1'b1), .IMAGE(IMG)) u1 (
    .clk(clk), .chipEn(ce), .oeRst(pinHi),
    .dataOut(doHi), .dataOutEn(enHi), .cascadeEn(caHi));

  function automatic bit expEn(bit c, bit r, bit d);
    return c && !r && !d;
  endfunction

  function automatic bit expCasc(bit c, bit r, bit d);
    return d && c && !r;
  endfunction

  function automatic bit expData(bit c, bit r, bit d, int a);
    return expEn(c, r, d) ? IMG[a] : 1'b0;
  endfunction

  task automatic chk(string tag, string inst, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b addr=%0d", tag, inst, act, exp, mAddr);
    end
  endtask

  task automatic step(bit c, bit r, string ph);
    bit eEn, eCa, eDo;
    @(negedge clk);
    ce = c;
    rst = r;
    #1;
    eEn = expEn(c, r, mDone);
    eCa = expCasc(c, r, mDone);
    eDo = expData(c, r, mDone, mAddr);
    chk({ph, "/R6 en"}, "lowPol", enLo, eEn);
    chk({ph, "/R6 en"}, "highPol", enHi, eEn);
    chk({ph, "/R8 casc"}, "lowPol", caLo, eCa);
    chk({ph, "/R8 casc"}, "highPol", caHi, eCa);
    chk({ph, "/R4 data"}, "lowPol", doLo, eDo);
    chk({ph, "/R4 data"}, "highPol", doHi, eDo);
    @(posedge clk);
    if (r) begin
      mAddr = 0;
      mDone = 1'b0;
    end else if (c && !mDone) begin
      if (mAddr == DEPTH - 1) mDone = 1'b1;
      else mAddr++;
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2417);
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R1");
    // R3 / R7: whole stream then terminal hold
    for (int i = 0; i < DEPTH + 6; i++) step(1'b1, 1'b0, "R3R7");
    step(1'b0, 1'b0, "R7");
    step(1'b1, 1'b0, "R7");
    // R1: reset releases and restarts the stream
    step(1'b1, 1'b1, "R1");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, "R3");
    // R5: deselected holds the address
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R5");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R5");
    // R1: reset in mid-stream
    step(1'b0, 1'b1, "R1");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R1");
    // R2: random traffic on both polarity variants
    for (int i = 0; i < 900; i++)
      step(($urandom % 8) != 0, ($urandom % 90) == 0, "R2");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule